// File: doc/BRIEF.md
# Descriptor-Chained DMA Address Sequencer

This block produces the word addresses that a block-data controller's data path uses to move a transfer to or from memory. Software loads the first buffer's base and byte size and the first link word, then starts the engine. The block streams one word address per accepted data beat until the buffer's byte count is used up.

In list mode the link word names the next descriptor: a byte offset from a programmed list base and three flags. The block reads three consecutive words at that address through a single-outstanding memory read port: the link word first, then the buffer base, then the buffer size. The flags of the current link word select which of the newly read fields take effect. A link word without its continue flag marks the final buffer. With list mode off, or with the first link word already marking the final buffer, the block runs a single buffer and never reads memory. A misaligned buffer stops the engine with an error. Writing a zero enable bit stops it at any time.

Top module: `lldma_chain_fetch`

## Requirements
- R1: While reset is held and after it is released, `done`, `err`, `beat_valid` and `mem_req` are low.
- R2: Register select codes are 0 control, 1 list base, 2 first link word, 3 first buffer base and 4 first buffer size. Control bit 0 is enable and bit 1 is list mode. Writing control with bit 0 set while idle starts a run. With list mode off, the block issues ceil(size/4) beats at base, base+4, and so on, then raises `done`, and makes no memory reads.
- R3: With list mode on but bit 31 (continue) of the current link word clear, only the current buffer is streamed, then `done` is raised, and no memory read is made.
- R4: A descriptor fetch is three reads at list base + link[15:0], then +4, then +8. They return, in order, the next link word, the buffer base and the buffer size. `mem_req` and `mem_addr` stay unchanged until `mem_rvalid`.
- R5: Buffers are streamed in chain order. After a buffer's last beat, the next descriptor is fetched only if the current link's bit 31 is set; otherwise `done` is raised.
- R6: If bit 29 (take base) of the current link is clear, the next buffer continues at the address just after the previous buffer. If bit 30 (take size) is clear, the previous size is reused.
- R7: A buffer whose base has bits [1:0] not zero raises `err` and issues no beat for that buffer.
- R8: A buffer that is not the last one must have a size that is a multiple of 2^BLK_LOG2 bytes (16 by default), or `err` is raised before any of its beats. The last buffer may have any size.
- R9: A control write with bit 0 clear stops the engine. On the next cycle `beat_valid`, `mem_req`, `done` and `err` are low.
- R10: While a run is busy, writes to the list base, link, base and size registers are ignored, and so is a control write with bit 0 set.
- R11: While `beat_valid` is high and `beat_ready` is low, `beat_valid` and `beat_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| beat_valid | output | 1 | A word address is offered |
| beat_ready | input | 1 | Data path accepts the beat |
| beat_addr | output | ADDR_W | Word address of the beat |
| done | output | 1 | Run finished normally |
| err | output | 1 | Run stopped on misalignment |

## Verification
The address generator is driven with a single buffer whose size is not a whole number of words, a three-buffer chain streamed under a toggling ready, and a chain whose link flags suppress the base and size loads. Between them these separate correct beat counts, fetch addresses and descriptor-word ordering from wrong field reuse. Misaligned bases and sizes check where the error cuts the stream. A mid-run stop and register writes made while busy check that control takes effect at once and that preloaded state is not overwritten.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_LBASE = 3'd1;
  localparam logic [2:0] SEL_LINK  = 3'd2;
  localparam logic [2:0] SEL_BASE  = 3'd3;
  localparam logic [2:0] SEL_SIZE  = 3'd4;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_LIST = 1;

  localparam int LNK_CONT      = 31;
  localparam int LNK_TAKE_SIZE = 30;
  localparam int LNK_TAKE_BASE = 29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_STREAM, ST_FETCH, ST_DONE, ST_ERR
  } seq_state_t;
endpackage

// File: rtl/lldma_regbank.sv
module lldma_regbank
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] lbase_o,
  output logic [WORD_W-1:0] link_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              list_en_o,
  output logic              start_o,
  output logic              stop_o
);
  logic wr_ok;
  assign wr_ok   = we && !busy;
  assign start_o = wr_ok && (sel == SEL_CTRL) && wdata[CTRL_EN];
  assign stop_o  = we && (sel == SEL_CTRL) && !wdata[CTRL_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbase_o   <= '0;
      link_o    <= '0;
      base_o    <= '0;
      size_o    <= '0;
      list_en_o <= 1'b0;
    end else if (wr_ok) begin
      case (sel)
        SEL_CTRL:  list_en_o <= wdata[CTRL_LIST];
        SEL_LBASE: lbase_o   <= wdata[ADDR_W-1:0];
        SEL_LINK:  link_o    <= wdata;
        SEL_BASE:  base_o    <= wdata[ADDR_W-1:0];
        SEL_SIZE:  size_o    <= wdata[SIZE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lldma_desc_reader.sv
module lldma_desc_reader #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        idx_o,
  output logic              take_o
);
  logic [1:0] idx_q, idx_d;
  logic       idx_en;

  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    if (!go) begin
      idx_en = 1'b1;
      idx_d  = '0;
    end else if (rvalid) begin
      idx_en = 1'b1;
      idx_d  = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign mem_req  = go;
  assign mem_addr = start_addr + {{(ADDR_W-4){1'b0}}, idx_q, 2'b00};
  assign idx_o    = idx_q;
  assign take_o   = go && rvalid;
endmodule

// File: rtl/lldma_beat_walker.sv
module lldma_beat_walker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic              active,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              empty
);
  localparam logic [SIZE_W-1:0] WBYTES = SIZE_W'(4);
  localparam logic [ADDR_W-1:0] WSTEP  = ADDR_W'(4);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SIZE_W-1:0] rem_q, rem_d;
  logic              en;
  logic              fire;

  assign empty = (rem_q == '0);
  assign valid = active && !empty;
  assign fire  = valid && ready;
  assign addr  = addr_q;

  always_comb begin
    en     = load || fire;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load) begin
      addr_d = base;
      rem_d  = size;
    end else if (fire) begin
      addr_d = addr_q + WSTEP;
      rem_d  = (rem_q <= WBYTES) ? '0 : rem_q - WBYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/lldma_chain_fetch.sv
module lldma_chain_fetch
  import lldma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 32,
  parameter int OFF_W   = 16,
  parameter int BLK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              done,
  output logic              err
);
  logic [1:0] rsync;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_ns = rsync[1];

  seq_state_t        st_q, st_d;
  logic              busy, start, stop, list_en;
  logic [ADDR_W-1:0] r_lbase, r_base;
  logic [WORD_W-1:0] r_link;
  logic [SIZE_W-1:0] r_size;

  logic [WORD_W-1:0] cur_link, new_link;
  logic [ADDR_W-1:0] cur_base, walk_addr, fetch_base;
  logic [SIZE_W-1:0] cur_size;
  logic [1:0]        widx;
  logic              take, walk_load, walk_empty;
  logic              is_last, size_odd, bad;

  assign busy = (st_q == ST_CHECK) || (st_q == ST_STREAM) || (st_q == ST_FETCH);

  lldma_regbank #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .lbase_o(r_lbase), .link_o(r_link), .base_o(r_base),
    .size_o(r_size), .list_en_o(list_en), .start_o(start), .stop_o(stop)
  );

  assign fetch_base = r_lbase + {{(ADDR_W-OFF_W){1'b0}}, cur_link[OFF_W-1:0]};

  lldma_desc_reader #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_ns), .go(st_q == ST_FETCH), .start_addr(fetch_base),
    .rvalid(mem_rvalid), .mem_req(mem_req), .mem_addr(mem_addr),
    .idx_o(widx), .take_o(take)
  );

  lldma_beat_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_walk (
    .clk(clk), .rst_n(rst_ns), .load(walk_load), .base(cur_base),
    .size(cur_size), .active(st_q == ST_STREAM), .ready(beat_ready),
    .valid(beat_valid), .addr(walk_addr), .empty(walk_empty)
  );
  assign beat_addr = walk_addr;

  generate
    if (BLK_LOG2 > 0) begin : g_blk_chk
      assign size_odd = |cur_size[BLK_LOG2-1:0];
    end else begin : g_no_blk_chk
      assign size_odd = 1'b0;
    end
  endgenerate

  assign is_last = !list_en || !cur_link[LNK_CONT];
  assign bad     = (cur_base[1:0] != 2'b00) || (!is_last && size_odd);

  logic unused_rsvd;
  assign unused_rsvd = ^cur_link[LNK_TAKE_BASE-1:OFF_W];

  always_comb begin
    st_d      = st_q;
    walk_load = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE, ST_ERR: if (start) st_d = ST_CHECK;
      ST_CHECK: begin
        if (bad) st_d = ST_ERR;
        else begin
          st_d      = ST_STREAM;
          walk_load = 1'b1;
        end
      end
      ST_STREAM: if (walk_empty) st_d = is_last ? ST_DONE : ST_FETCH;
      ST_FETCH:  if (take && widx == 2'd2) st_d = ST_CHECK;
      default:   st_d = ST_IDLE;
    endcase
    if (stop) begin
      st_d      = ST_IDLE;
      walk_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  logic preload;
  assign preload = start && !busy;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cur_link <= '0;
      cur_base <= '0;
      cur_size <= '0;
      new_link <= '0;
    end else if (preload) begin
      cur_link <= r_link;
      cur_base <= r_base;
      cur_size <= r_size;
    end else if (take) begin
      case (widx)
        2'd0: new_link <= mem_rdata;
        2'd1: cur_base <= cur_link[LNK_TAKE_BASE] ? mem_rdata[ADDR_W-1:0] : walk_addr;
        default: begin
          if (cur_link[LNK_TAKE_SIZE]) cur_size <= mem_rdata[SIZE_W-1:0];
          cur_link <= new_link;
        end
      endcase
    end
  end

  assign done = (st_q == ST_DONE);
  assign err  = (st_q == ST_ERR);
endmodule

// File: rtl/lldma_chain_fetch_sva.sv
module lldma_chain_fetch_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_sel,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              done,
  input logic              err
);
  logic halt;
  assign halt = reg_we && (reg_sel == 3'd0) && !reg_wdata[0];

  a_r11_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && !halt |=> beat_valid && $stable(beat_addr));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid && !halt |=> mem_req && $stable(mem_addr));

  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !beat_valid && !mem_req && !done && !err);

  a_r7_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_addr[1:0] == 2'b00);

  a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !beat_valid && !mem_req);

  a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({beat_valid, mem_req, done, err}) <= 1);
endmodule

bind lldma_chain_fetch lldma_chain_fetch_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_addr(beat_addr), .done(done), .err(err)
);

// File: tb/lldma_chain_fetch_bench.sv
module lldma_chain_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        beat_valid;
  logic        beat_ready;
  logic [31:0] beat_addr;
  logic        done, err;

  always #4 clk = ~clk;

  lldma_chain_fetch u_lldma_chain_fetch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_addr(beat_addr), .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;
  logic        clr = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] mem [0:255];
  logic [31:0] rec [0:255];
  logic [31:0] mlog [0:31];
  logic [31:0] expq [0:255];
  int nrec, nm, nexp;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      beat_ready <= 1'b1;
      nrec <= 0;
      nm   <= 0;
    end else begin
      beat_ready <= stall ? ~beat_ready : 1'b1;
      if (clr) begin
        nrec <= 0;
        nm   <= 0;
      end else begin
        if (beat_valid && beat_ready && nrec < 256) begin
          rec[nrec] <= beat_addr;
          nrec <= nrec + 1;
        end
        if (mem_req && !mem_rvalid && nm < 32) begin
          mlog[nm] <= mem_addr;
          nm <= nm + 1;
        end
      end
      if (mem_req && !mem_rvalid) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
      end else begin
        mem_rvalid <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fresh();
    wr(3'd0, 32'h0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    nexp = 0;
  endtask

  task automatic add_buf(input logic [31:0] b, input int sz);
    for (int k = 0; k < (sz + 3) / 4; k++) begin
      expq[nexp] = b + 32'(4 * k);
      nexp++;
    end
  endtask

  task automatic wait_end(input string req);
    int n = 0;
    while (!(done || err) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, req, "run ended", 32'(n), 32'd3000);
  endtask

  task automatic cmp_beats(input string req);
    int bad = -1;
    chk(nrec == nexp, req, "beat count", 32'(nrec), 32'(nexp));
    for (int k = 0; k < nexp && k < nrec; k++)
      if (bad < 0 && rec[k] !== expq[k]) bad = k;
    chk(bad < 0, req, "beat address", (bad < 0) ? 32'h0 : rec[bad],
        (bad < 0) ? 32'h0 : expq[bad]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done && !err, "R1", "done/err in reset", {30'd0, done, err}, 32'h0);
    chk(!beat_valid && !mem_req, "R1", "valid/req in reset",
        {30'd0, beat_valid, mem_req}, 32'h0);
  endtask

  task automatic t_single();
    fresh();
    wr(3'd2, 32'hE000_000C); wr(3'd3, 32'h100); wr(3'd4, 32'd10);
    wr(3'd0, 32'h1);
    add_buf(32'h100, 10);
    wait_end("R2");
    chk(done && !err, "R2", "done after single buffer", {31'd0, done}, 32'h1);
    cmp_beats("R2");
    chk(nm == 0, "R2", "no memory reads", 32'(nm), 32'h0);
  endtask

  task automatic t_one_in_list();
    fresh();
    wr(3'd1, 32'h80); wr(3'd2, 32'h6000_000C); wr(3'd3, 32'h140);
    wr(3'd4, 32'd8); wr(3'd0, 32'h3);
    add_buf(32'h140, 8);
    wait_end("R3");
    chk(done, "R3", "done", {31'd0, done}, 32'h1);
    cmp_beats("R3");
    chk(nm == 0, "R3", "no memory reads", 32'(nm), 32'h0);
  endtask

  task automatic t_chain();
    fresh();
    mem[35] = 32'hE000_0018; mem[36] = 32'h300; mem[37] = 32'd16;
    mem[38] = 32'h0;         mem[39] = 32'h400; mem[40] = 32'd6;
    stall = 1'b1;
    wr(3'd1, 32'h80); wr(3'd2, 32'hE000_000C); wr(3'd3, 32'h200);
    wr(3'd4, 32'd32); wr(3'd0, 32'h3);
    add_buf(32'h200, 32); add_buf(32'h300, 16); add_buf(32'h400, 6);
    wait_end("R5");
    stall = 1'b0;
    chk(done && !err, "R5", "done at chain end", {30'd0, done, err}, 32'h2);
    cmp_beats("R5");
    chk(nm == 6, "R4", "fetch read count", 32'(nm), 32'd6);
    for (int k = 0; k < 6; k++)
      chk(mlog[k] == 32'h8C + 32'(4 * k), "R4", "fetch address", mlog[k],
          32'h8C + 32'(4 * k));
  endtask

  task automatic t_no_take();
    fresh();
    mem[35] = 32'h0; mem[36] = 32'h700; mem[37] = 32'h99;
    wr(3'd1, 32'h80); wr(3'd2, 32'h8000_000C); wr(3'd3, 32'h200);
    wr(3'd4, 32'd16); wr(3'd0, 32'h3);
    add_buf(32'h200, 16); add_buf(32'h210, 16);
    wait_end("R6");
    chk(done, "R6", "done", {31'd0, done}, 32'h1);
    cmp_beats("R6");
  endtask

  task automatic t_misalign();
    fresh();
    wr(3'd2, 32'h0); wr(3'd3, 32'h202); wr(3'd4, 32'd8); wr(3'd0, 32'h1);
    wait_end("R7");
    chk(err && !done, "R7", "err on base", {30'd0, err, done}, 32'h2);
    chk(nrec == 0, "R7", "no beats", 32'(nrec), 32'h0);
    fresh();
    mem[35] = 32'hE000_0018; mem[36] = 32'h300; mem[37] = 32'd20;
    wr(3'd1, 32'h80); wr(3'd2, 32'hE000_000C); wr(3'd3, 32'h200);
    wr(3'd4, 32'd32); wr(3'd0, 32'h3);
    add_buf(32'h200, 32);
    wait_end("R8");
    chk(err, "R8", "err on unaligned middle size", {31'd0, err}, 32'h1);
    cmp_beats("R8");
  endtask

  task automatic t_stop();
    int held;
    fresh();
    wr(3'd2, 32'h0); wr(3'd3, 32'h100); wr(3'd4, 32'd400); wr(3'd0, 32'h1);
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h0);
    chk(!beat_valid && !done && !err, "R9", "stopped outputs",
        {29'd0, beat_valid, done, err}, 32'h0);
    held = nrec;
    repeat (10) @(negedge clk);
    chk(nrec == held && held < 100, "R9", "no beats after stop", 32'(nrec),
        32'(held));
  endtask

  task automatic t_busy_writes();
    fresh();
    wr(3'd2, 32'h0); wr(3'd3, 32'h100); wr(3'd4, 32'd400); wr(3'd0, 32'h1);
    wr(3'd3, 32'h5000);
    wr(3'd0, 32'h3);
    add_buf(32'h100, 400);
    wait_end("R10");
    cmp_beats("R10");
    fresh();
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    chk(nrec > 0 && rec[0] == 32'h100, "R10", "base kept after busy write",
        rec[0], 32'h100);
    wait_end("R10");
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    nexp = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_one_in_list();
    t_chain();
    t_no_take();
    t_misalign();
    t_stop();
    t_busy_writes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule